// File: doc/BRIEF.md
# Stream Channel Unpacker

The block takes wide words from a streaming source and hands their samples out to N channel ports on demand. A word holds N samples of W bits, and the consumer side sees one FIFO-style read port per channel. All channels share one read-request line, and each channel has its own enable bit. A request takes one sample for each enabled channel, in stream order. It is answered exactly one cycle later, either by a valid pulse with data on the enabled lanes or by an underflow pulse.

Samples are kept in an internal buffer with room for two words. When fewer than N channels are enabled, one stream word serves several requests, and a request may use the tail of one word and the head of the next. The stream ready signal is high only while a whole new word fits without overwriting unread samples. The enable mask is expected to stay fixed while data flows.

Top module: `stream_unpacker`

## Requirements
- R1: After a synchronous reset the buffer is empty: `s_ready` is high, and `rd_valid` and `rd_underflow` are low.
- R2: `s_ready` is high exactly when the buffer holds at most N unread samples. A word offered while `s_ready` is low is not taken and does not change later output.
- R3: A request made while at least k samples are buffered (k = number of set bits in `rd_en`) raises `rd_valid` in the next cycle. In that cycle the enabled lanes carry the k oldest samples, the lowest enabled channel getting the oldest. Lane j is `rd_data[j*W +: W]`, and stream sample i is `s_data[i*W +: W]`, with sample 0 earliest.
- R4: A request made while fewer than k samples are buffered raises `rd_underflow` in the next cycle and consumes nothing.
- R5: `rd_valid` and `rd_underflow` are never high together, and neither is high in a cycle that does not follow a request.
- R6: Samples carry over between words: with k < N, consecutive requests continue where the previous one stopped, across word boundaries.
- R7: Every mask unpacks correctly, including non-contiguous masks. An all-zero mask answers with `rd_valid` and consumes nothing.
- R8: A reset in the middle of a stream discards all buffered samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Stream word offered |
| s_ready | output | 1 | Buffer can accept a full word |
| s_data | input | N*W | Stream word, sample 0 in the low bits |
| rd_req | input | 1 | Shared read request |
| rd_en | input | N | Per-channel enable mask |
| rd_valid | output | 1 | Data answered for the previous request |
| rd_underflow | output | 1 | Previous request could not be served |
| rd_data | output | N*W | Channel lanes, valid on enabled lanes with `rd_valid` |

## Verification
A wrong sample count in the buffer shows up at the very next request. The answer flips between valid and underflow, or `s_ready` sits at the wrong level one cycle after the word that caused the error. A wrong shift or rank shows up as misplaced samples on the lanes in the answering cycle. When k does not divide N, this appears only on the request that straddles a word boundary, so the tests cover masks of one, two and three channels over several words. Reset faults show up as stale samples or a spurious valid on the first request after reset.

// File: rtl/stream_unpacker.sv
module stream_unpacker #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [N*W-1:0] s_data,
  input  logic         rd_req,
  input  logic [N-1:0] rd_en,
  output logic         rd_valid,
  output logic         rd_underflow,
  output logic [N*W-1:0] rd_data
);
  localparam int DEPTH = 2 * N;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0] store [DEPTH];
  logic [W-1:0] store_n [DEPTH];
  logic [CW-1:0] cnt, cnt_left;
  logic [CW-1:0] k;
  logic [CW-1:0] rank [N];
  logic take, push;

  always_comb begin
    k = '0;
    for (int j = 0; j < N; j++) begin
      rank[j] = k;
      k = k + CW'(rd_en[j]);
    end
  end

  assign s_ready  = (cnt <= CW'(N));
  assign push     = s_valid && s_ready;
  assign take     = rd_req && (cnt >= k);
  assign cnt_left = take ? cnt - k : cnt;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      store_n[i] = store[i];
      if (i < int'(cnt_left)) begin
        if (take && (i + int'(k) < DEPTH))
          store_n[i] = store[i + int'(k)];
      end else if (push && (i - int'(cnt_left) < N)) begin
        store_n[i] = s_data[(i - int'(cnt_left))*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      rd_valid     <= 1'b0;
      rd_underflow <= 1'b0;
    end else begin
      cnt          <= cnt_left + (push ? CW'(N) : CW'(0));
      rd_valid     <= take;
      rd_underflow <= rd_req && !take;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) store[i] <= store_n[i];
  end

  generate
    for (genvar j = 0; j < N; j++) begin : g_lane
      always_ff @(posedge clk)
        rd_data[j*W +: W] <= rd_en[j] ? store[rank[j]] : '0;
    end
  endgenerate
endmodule

// File: rtl/stream_unpacker_chk.sv
module stream_unpacker_chk #(
  parameter int N = 4,
  parameter int CW = 4
) (
  input logic clk,
  input logic rst,
  input logic rd_req,
  input logic rd_valid,
  input logic rd_underflow,
  input logic s_ready,
  input logic s_valid,
  input logic [CW-1:0] cnt
);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_underflow));
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !(rd_valid || rd_underflow));
  a_r1_reset_ready: assert property (@(posedge clk)
    rst |=> (s_ready && !rd_valid && !rd_underflow));
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(2*N));
  a_r2_refuse_full: assert property (@(posedge clk) disable iff (rst)
    (!s_ready && !rd_req) |=> !s_ready && $stable(cnt));
endmodule

bind stream_unpacker stream_unpacker_chk #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_valid(rd_valid),
  .rd_underflow(rd_underflow), .s_ready(s_ready), .s_valid(s_valid), .cnt(cnt)
);

// File: tb/stream_unpacker_tb_top.sv
module stream_unpacker_tb_top;
  localparam int N = 4;
  localparam int W = 16;

  logic clk = 0;
  logic rst = 1;
  logic s_valid = 0;
  logic s_ready;
  logic [N*W-1:0] s_data = '0;
  logic rd_req = 0;
  logic [N-1:0] rd_en = '0;
  logic rd_valid, rd_underflow;
  logic [N*W-1:0] rd_data;

  int errors = 0;
  int checks = 0;
  int model[$];

  always #2.5 clk = ~clk;

  stream_unpacker #(.N(N), .W(W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_word(input int base, input string req);
    logic exp_ready;
    @(negedge clk);
    exp_ready = (model.size() <= N);
    chk(s_ready == exp_ready, req, s_ready, exp_ready);
    s_valid = 1;
    for (int i = 0; i < N; i++) s_data[i*W +: W] = W'(base + i);
    if (exp_ready) for (int i = 0; i < N; i++) model.push_back(base + i);
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic request(input logic [N-1:0] mask, input string req);
    int k;
    int exp_s [N];
    bit ok;
    @(negedge clk);
    k = $countones(mask);
    ok = (model.size() >= k);
    for (int j = 0; j < N; j++) exp_s[j] = 0;
    if (ok) for (int j = 0; j < N; j++) if (mask[j]) exp_s[j] = model.pop_front();
    rd_req = 1;
    rd_en = mask;
    @(negedge clk);
    rd_req = 0;
    chk(rd_valid == ok, req, rd_valid, ok);
    chk(rd_underflow == !ok, req, rd_underflow, !ok);
    if (ok) for (int j = 0; j < N; j++)
      if (mask[j]) chk(rd_data[j*W +: W] == W'(exp_s[j]), req, rd_data[j*W +: W], exp_s[j]);
    @(negedge clk);
    chk(!rd_valid && !rd_underflow, "R5", {rd_valid, rd_underflow}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    model.delete();
    chk(s_ready && !rd_valid && !rd_underflow, "R1", {s_ready, rd_valid, rd_underflow}, 3'b100);
  endtask

  task automatic t_full_mask();
    push_word(16'h100, "R2");
    push_word(16'h200, "R2");
    request(4'b1111, "R3");
    request(4'b1111, "R3");
    request(4'b1111, "R4");
  endtask

  task automatic t_single();
    push_word(16'h300, "R2");
    push_word(16'h400, "R2");
    push_word(16'h500, "R2");
    for (int r = 0; r < 8; r++) request(4'b0100, "R6");
    request(4'b0100, "R4");
  endtask

  task automatic t_three();
    push_word(16'h600, "R2");
    request(4'b1011, "R7");
    request(4'b1011, "R4");
    push_word(16'h700, "R2");
    request(4'b1011, "R6");
    request(4'b0110, "R7");
    request(4'b0000, "R7");
    request(4'b1001, "R4");
  endtask

  task automatic t_reset_mid();
    push_word(16'h800, "R2");
    request(4'b0001, "R3");
    do_reset();
    request(4'b0001, "R8");
    push_word(16'h900, "R8");
    request(4'b0011, "R8");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(s_ready && !rd_valid && !rd_underflow, "R1", {s_ready, rd_valid, rd_underflow}, 3'b100);
    request(4'b1111, "R4");
    t_full_mask();
    t_single();
    t_three();
    t_reset_mid();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule